// File: doc/BRIEF.md
# Run-Time Tunable Iterative Sine/Cosine Oscillator

This block synthesizes a sinusoid whose frequency is chosen while the chip runs. A phase accumulator holds the current angle. At each sample boundary it moves forward by a step that is taken from an unsigned frequency word. The step is scaled so that the output frequency does not depend on how many cycles a sample takes. A single shift-add rotation stage runs once per clock for `ITER` clocks to turn the angle into a sine and cosine pair. The block then pulses a valid flag and begins the next sample on the following cycle.

The outputs are the sine, the cosine, the angle of the sample in binary angle units (a full turn equals 2^W), a one-cycle valid pulse, and a square wave at the target frequency. That square wave is taken from the accumulator's top bit. A strobe loads a new phase. A build-time switch chooses one of two output modes: the results can be held steady in output registers between samples, or the outputs can show the working registers directly. The reset is asynchronous, and its active level is a parameter.

Top module: `seq_cordic_osc`

## Requirements
- R1: While `rst_i` equals `RST_LVL` (default 0), the reset acts at once, without waiting for a clock edge. It forces `valid_o`, `sin_o`, `cos_o`, `angle_o` and `synth_clk_o` to zero.
- R2: After reset is released, `valid_o` goes high for exactly one cycle. This happens `ITER` cycles after the first rising edge, and again every `ITER` cycles after that.
- R3: The accumulator is `PH_W = clog2(CLK_HZ/MIN_HZ) + FRAC_W` bits wide (24 by default). At each sample boundary it advances by `freq_i * ITER * 2^PH_W / (CLK_HZ * FREQ_SCALE)`, taken modulo 2^PH_W (this is `freq_i * 256` by default). Each sample's `angle_o` is the top W bits of the accumulator at that sample's boundary.
- R4: `sin_o` and `cos_o` are within 8 LSB of `AMP*sin(2*pi*angle_o/2^W)` and `AMP*cos(2*pi*angle_o/2^W)`, in all four quadrants.
- R5: `freq_i` is sampled only on the boundary edge, which is the rising edge that ends a valid-high cycle, or the first edge after reset. A change on any other edge has no effect on the angles.
- R6: A one-cycle `load_i` sets the accumulator to `{new_phase_i, zeros}`, and this overrides the advance. If the load comes on a boundary edge, the sample starting there still uses the old phase, and the loaded phase becomes the next sample's angle. A load on any other edge becomes the next sample's angle.
- R7: With `CAPTURE=1`, `sin_o`, `cos_o` and `angle_o` change only when `valid_o` rises, and they hold steady between pulses.
- R8: With `CAPTURE=0`, the outputs show the working registers. They match the captured results while `valid_o` is high, and they change during a computation.
- R9: `synth_clk_o` is the accumulator's top bit. While `valid_o` is high, it equals bit W-1 of the next sample's angle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Asynchronous reset, active at level RST_LVL |
| load_i | input | 1 | Phase load strobe |
| new_phase_i | input | W | Phase to load, in binary angle units |
| freq_i | input | FREQ_W | Run-time frequency word |
| valid_o | output | 1 | One-cycle pulse when a sample is complete |
| sin_o | output | W | Sine, signed |
| cos_o | output | W | Cosine, signed |
| angle_o | output | W | Sample angle in binary angle units |
| synth_clk_o | output | 1 | Square wave at the target frequency |

## Verification
The assertions check the following on every cycle: the spacing and single-cycle width of the valid pulse, that the captured outputs stay frozen between pulses, that a phase load shows up at once on the square wave, that the output amplitude stays within its bound, and the output values during reset. Only the bench scenarios can show that each angle follows the accumulated steps, including frequency words that are changed in the middle of a computation and loads placed at different offsets. The same holds for the sine and cosine accuracy across quadrants, for the agreement of the uncaptured variant at each pulse, and for the reset taking effect between clock edges.

// File: rtl/scosc_pkg.sv
package scosc_pkg;

    // CORDIC gain compensation 1/1.64676 in Q16
    localparam int unsigned GAIN_INV_Q16 = 39797;

    // arctan(2^-idx) expressed as a fraction of a turn, scaled to 2^32
    function automatic logic [31:0] atan_turn32(input int unsigned idx);
        logic [31:0] r;
        case (idx)
            0:  r = 32'd536870912;
            1:  r = 32'd316933406;
            2:  r = 32'd167458907;
            3:  r = 32'd85004756;
            4:  r = 32'd42667331;
            5:  r = 32'd21354465;
            6:  r = 32'd10679838;
            7:  r = 32'd5340245;
            8:  r = 32'd2670163;
            9:  r = 32'd1335087;
            10: r = 32'd667544;
            11: r = 32'd333772;
            default: r = (idx > 31) ? 32'd0 : (32'd683565276 >> idx);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/scosc_phase.sv
module scosc_phase #(
    parameter int unsigned W      = 16,
    parameter int unsigned ITER   = 16,
    parameter int unsigned FREQ_W = 20,
    parameter int unsigned PH_W   = 24,
    parameter int unsigned CW     = 4,
    parameter logic [31:0] K_MUL  = 32'd256
) (
    input  logic              clk_i,
    input  logic              rst_a,
    input  logic              load_i,
    input  logic [W-1:0]      new_phase_i,
    input  logic [FREQ_W-1:0] freq_i,
    output logic [PH_W-1:0]   phase_o,
    output logic [CW-1:0]     cnt_o,
    output logic              start_o,
    output logic              last_o
);

    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic [CW-1:0]   cnt;
    } seq_t;

    seq_t s_d, s_q;
    logic [PH_W-1:0] step;

    always_comb begin
        step    = PH_W'(freq_i) * PH_W'(K_MUL);
        start_o = (s_q.cnt == '0);
        last_o  = (s_q.cnt == CW'(ITER - 1));
        s_d     = s_q;
        s_d.cnt = last_o ? '0 : s_q.cnt + 1'b1;
        if (load_i) begin
            s_d.phase = {new_phase_i, {(PH_W - W){1'b0}}};
        end else if (start_o) begin
            s_d.phase = s_q.phase + step;
        end
    end

    always_ff @(posedge clk_i or posedge rst_a) begin
        if (rst_a) s_q <= '0;
        else       s_q <= s_d;
    end

    assign phase_o = s_q.phase;
    assign cnt_o   = s_q.cnt;

endmodule

// File: rtl/scosc_cordic.sv
module scosc_cordic
    import scosc_pkg::*;
#(
    parameter int unsigned W    = 16,
    parameter int unsigned CW   = 4,
    parameter int unsigned AMP  = 30000,
    parameter int unsigned XW   = W + 2,
    parameter int unsigned ZW   = W + 4
) (
    input  logic                 clk_i,
    input  logic                 rst_a,
    input  logic                 start_i,
    input  logic [CW-1:0]        cnt_i,
    input  logic [W-1:0]         angle_i,
    output logic signed [XW-1:0] x_q_o,
    output logic signed [XW-1:0] y_q_o,
    output logic                 neg_q_o,
    output logic [W-1:0]         ang_q_o,
    output logic signed [XW-1:0] x_d_o,
    output logic signed [XW-1:0] y_d_o,
    output logic                 neg_d_o,
    output logic [W-1:0]         ang_d_o
);

    localparam int unsigned X_INIT = (AMP * GAIN_INV_Q16) >> 16;
    localparam int unsigned ZSH    = 32 - ZW;

    typedef struct packed {
        logic signed [XW-1:0] x;
        logic signed [XW-1:0] y;
        logic signed [ZW-1:0] z;
        logic                 neg;
        logic [W-1:0]         ang;
    } work_t;

    work_t w_d, w_q, w_in;
    logic                 flip;
    logic [W-1:0]         folded;
    logic signed [XW-1:0] x_sh, y_sh;
    logic signed [ZW-1:0] at;

    always_comb begin
        // fold the left half-plane onto the right half and remember to negate
        flip   = angle_i[W-1] ^ angle_i[W-2];
        folded = flip ? {~angle_i[W-1], angle_i[W-2:0]} : angle_i;
        if (start_i) begin
            w_in.x   = XW'(X_INIT);
            w_in.y   = '0;
            w_in.z   = {folded, 4'b0000};
            w_in.neg = flip;
            w_in.ang = angle_i;
        end else begin
            w_in = w_q;
        end
        x_sh = w_in.x >>> cnt_i;
        y_sh = w_in.y >>> cnt_i;
        at   = ZW'(atan_turn32(32'(cnt_i)) >> ZSH);
        w_d  = w_in;
        if (w_in.z[ZW-1]) begin
            w_d.x = w_in.x + y_sh;
            w_d.y = w_in.y - x_sh;
            w_d.z = w_in.z + at;
        end else begin
            w_d.x = w_in.x - y_sh;
            w_d.y = w_in.y + x_sh;
            w_d.z = w_in.z - at;
        end
    end

    always_ff @(posedge clk_i or posedge rst_a) begin
        if (rst_a) w_q <= '0;
        else       w_q <= w_d;
    end

    assign x_q_o   = w_q.x;
    assign y_q_o   = w_q.y;
    assign neg_q_o = w_q.neg;
    assign ang_q_o = w_q.ang;
    assign x_d_o   = w_d.x;
    assign y_d_o   = w_d.y;
    assign neg_d_o = w_d.neg;
    assign ang_d_o = w_d.ang;

endmodule

// File: rtl/scosc_out.sv
module scosc_out #(
    parameter int unsigned W       = 16,
    parameter int unsigned XW      = W + 2,
    parameter bit          CAPTURE = 1'b1
) (
    input  logic                 clk_i,
    input  logic                 rst_a,
    input  logic                 last_i,
    input  logic signed [XW-1:0] x_i,
    input  logic signed [XW-1:0] y_i,
    input  logic                 neg_i,
    input  logic [W-1:0]         ang_i,
    output logic                 valid_o,
    output logic signed [W-1:0]  sin_o,
    output logic signed [W-1:0]  cos_o,
    output logic [W-1:0]         angle_o
);

    function automatic logic [W-1:0] fix_sign(input logic signed [XW-1:0] v, input logic n);
        logic signed [XW-1:0] r;
        r = n ? -v : v;
        return r[W-1:0];
    endfunction

    typedef struct packed {
        logic         valid;
        logic [W-1:0] sin;
        logic [W-1:0] cos;
        logic [W-1:0] ang;
    } res_t;

    res_t r_d, r_q;

    generate
        if (CAPTURE) begin : g_capture
            always_comb begin
                r_d       = r_q;
                r_d.valid = last_i;
                if (last_i) begin
                    r_d.sin = fix_sign(y_i, neg_i);
                    r_d.cos = fix_sign(x_i, neg_i);
                    r_d.ang = ang_i;
                end
            end
        end else begin : g_track
            always_comb begin
                r_d       = '0;
                r_d.valid = last_i;
            end
        end
    endgenerate

    always_ff @(posedge clk_i or posedge rst_a) begin
        if (rst_a) r_q <= '0;
        else       r_q <= r_d;
    end

    assign valid_o = r_q.valid;
    assign sin_o   = CAPTURE ? r_q.sin : fix_sign(y_i, neg_i);
    assign cos_o   = CAPTURE ? r_q.cos : fix_sign(x_i, neg_i);
    assign angle_o = CAPTURE ? r_q.ang : ang_i;

endmodule

// File: rtl/seq_cordic_osc.sv
module seq_cordic_osc #(
    parameter int unsigned W          = 16,
    parameter int unsigned ITER       = 16,
    parameter int unsigned FREQ_W     = 20,
    parameter int unsigned CLK_HZ     = 1048576,
    parameter int unsigned MIN_HZ     = 16,
    parameter int unsigned FREQ_SCALE = 1,
    parameter int unsigned FRAC_W     = 8,
    parameter int unsigned AMP        = 30000,
    parameter bit          CAPTURE    = 1'b1,
    parameter logic        RST_LVL    = 1'b0
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,
    input  logic [W-1:0]      new_phase_i,
    input  logic [FREQ_W-1:0] freq_i,
    output logic              valid_o,
    output logic signed [W-1:0] sin_o,
    output logic signed [W-1:0] cos_o,
    output logic [W-1:0]      angle_o,
    output logic              synth_clk_o
);

    localparam int unsigned ACC_W = $clog2(CLK_HZ / MIN_HZ);
    localparam int unsigned PH_W  = ACC_W + FRAC_W;
    localparam int unsigned CW    = $clog2(ITER);
    localparam int unsigned XW    = W + 2;
    localparam logic [31:0] K_MUL =
        32'(((64'd1 << PH_W) * 64'(ITER)) / (64'(CLK_HZ) * 64'(FREQ_SCALE)));

    logic                 rst_a;
    logic [PH_W-1:0]      phase;
    logic [CW-1:0]        cnt;
    logic                 start, last;
    logic signed [XW-1:0] x_q, y_q, x_d, y_d, x_sel, y_sel;
    logic                 neg_q, neg_d, neg_sel;
    logic [W-1:0]         ang_q, ang_d, ang_sel;

    assign rst_a = (rst_i == RST_LVL);

    scosc_phase #(
        .W(W), .ITER(ITER), .FREQ_W(FREQ_W), .PH_W(PH_W), .CW(CW), .K_MUL(K_MUL)
    ) phase_i (
        .clk_i(clk_i), .rst_a(rst_a), .load_i(load_i), .new_phase_i(new_phase_i),
        .freq_i(freq_i), .phase_o(phase), .cnt_o(cnt), .start_o(start), .last_o(last)
    );

    scosc_cordic #(
        .W(W), .CW(CW), .AMP(AMP), .XW(XW), .ZW(W + 4)
    ) cordic_i (
        .clk_i(clk_i), .rst_a(rst_a), .start_i(start), .cnt_i(cnt),
        .angle_i(phase[PH_W-1 -: W]),
        .x_q_o(x_q), .y_q_o(y_q), .neg_q_o(neg_q), .ang_q_o(ang_q),
        .x_d_o(x_d), .y_d_o(y_d), .neg_d_o(neg_d), .ang_d_o(ang_d)
    );

    // captured mode latches the final iteration result, tracking mode shows the registers
    assign x_sel   = CAPTURE ? x_d   : x_q;
    assign y_sel   = CAPTURE ? y_d   : y_q;
    assign neg_sel = CAPTURE ? neg_d : neg_q;
    assign ang_sel = CAPTURE ? ang_d : ang_q;

    scosc_out #(
        .W(W), .XW(XW), .CAPTURE(CAPTURE)
    ) out_i (
        .clk_i(clk_i), .rst_a(rst_a), .last_i(last),
        .x_i(x_sel), .y_i(y_sel), .neg_i(neg_sel), .ang_i(ang_sel),
        .valid_o(valid_o), .sin_o(sin_o), .cos_o(cos_o), .angle_o(angle_o)
    );

    assign synth_clk_o = phase[PH_W-1];

endmodule

// File: rtl/scosc_chk.sv
module scosc_chk #(
    parameter int unsigned W       = 16,
    parameter int unsigned ITER    = 16,
    parameter int unsigned AMP     = 30000,
    parameter bit          CAPTURE = 1'b1,
    parameter logic        RST_LVL = 1'b0
) (
    input logic                clk_i,
    input logic                rst_i,
    input logic                load_i,
    input logic [W-1:0]        new_phase_i,
    input logic                valid_o,
    input logic signed [W-1:0] sin_o,
    input logic signed [W-1:0] cos_o,
    input logic [W-1:0]        angle_o,
    input logic                synth_clk_o
);

    localparam int LIM = int'(AMP) + 8;

    logic        rst_act;
    int unsigned gap_q;
    logic        seen_q;

    assign rst_act = (rst_i == RST_LVL);

    always_ff @(posedge clk_i or posedge rst_act) begin
        if (rst_act) begin
            gap_q  <= 0;
            seen_q <= 1'b0;
        end else if (valid_o) begin
            gap_q  <= 0;
            seen_q <= 1'b1;
        end else if (gap_q < ITER) begin
            gap_q  <= gap_q + 1;
        end
    end

    p_reset_r1: assert property (@(posedge clk_i)
        rst_act |-> (!valid_o && sin_o == '0 && cos_o == '0 && angle_o == '0 && !synth_clk_o));

    p_pulse_r2: assert property (@(posedge clk_i) disable iff (rst_act)
        valid_o |=> !valid_o);

    p_spacing_r2: assert property (@(posedge clk_i) disable iff (rst_act)
        (valid_o && seen_q) |-> (gap_q == ITER - 1));

    p_load_r6: assert property (@(posedge clk_i) disable iff (rst_act)
        load_i |=> (synth_clk_o == $past(new_phase_i[W-1])));

    p_amp_r4: assert property (@(posedge clk_i) disable iff (rst_act)
        valid_o |-> (int'(sin_o) <= LIM && int'(sin_o) >= -LIM &&
                     int'(cos_o) <= LIM && int'(cos_o) >= -LIM));

    generate
        if (CAPTURE) begin : g_hold
            p_hold_r7: assert property (@(posedge clk_i) disable iff (rst_act)
                (!$stable(sin_o) || !$stable(cos_o) || !$stable(angle_o)) |-> valid_o);
        end
    endgenerate

endmodule

bind seq_cordic_osc scosc_chk #(
    .W(W), .ITER(ITER), .AMP(AMP), .CAPTURE(CAPTURE), .RST_LVL(RST_LVL)
) chk_i (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(load_i), .new_phase_i(new_phase_i),
    .valid_o(valid_o), .sin_o(sin_o), .cos_o(cos_o), .angle_o(angle_o),
    .synth_clk_o(synth_clk_o)
);

// File: tb/seq_cordic_osc_tb_top.sv
`timescale 1ns/1ps
module seq_cordic_osc_tb_top;

    localparam int W    = 16;
    localparam int ITER = 16;
    localparam int AMP  = 30000;
    localparam int TOL  = 8;
    localparam real PI  = 3.14159265358979;

    typedef struct {
        logic [W-1:0] ang;
        logic         nclk;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        load;
    logic [W-1:0] nphase;
    logic [19:0] freq;
    logic        valid, sclk, valid_nc, sclk_nc;
    logic signed [W-1:0] sin_v, cos_v, sin_nc, cos_nc;
    logic [W-1:0] ang_v, ang_nc;

    int n_chk = 0;
    int n_fail = 0;
    exp_t sb_q[$];
    longint unsigned model_ph = 0;

    always #2 clk = ~clk;

    seq_cordic_osc dut_i (
        .clk_i(clk), .rst_i(rst_n), .load_i(load), .new_phase_i(nphase), .freq_i(freq),
        .valid_o(valid), .sin_o(sin_v), .cos_o(cos_v), .angle_o(ang_v), .synth_clk_o(sclk)
    );

    seq_cordic_osc #(.CAPTURE(1'b0)) dut_nc_i (
        .clk_i(clk), .rst_i(rst_n), .load_i(load), .new_phase_i(nphase), .freq_i(freq),
        .valid_o(valid_nc), .sin_o(sin_nc), .cos_o(cos_nc), .angle_o(ang_nc), .synth_clk_o(sclk_nc)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one sample slot: the frequency word is only meaningful on the boundary edge
    task automatic slot(input int f, input bit do_load, input int off, input logic [W-1:0] val);
        exp_t e;
        e.ang = model_ph[23:8];
        if (do_load) model_ph = {val, 8'h00};
        else         model_ph = (model_ph + longint'(f) * 256) & 64'hFF_FFFF;
        e.nclk = model_ph[23];
        sb_q.push_back(e);
        for (int k = 0; k < ITER; k++) begin
            freq = (k == 0) ? 20'(f) : (20'(f) ^ 20'hA5A5A);   // R5 noise off-boundary
            load = do_load && (k == off);
            nphase = (do_load && (k == off)) ? val : ~val;
            @(negedge clk);
        end
        load = 1'b0;
    endtask

    // monitor / scoreboard
    int cyc = 0, last_cyc = 0, nc_diff = 0;
    bit seen = 0, hold_bad = 0;
    logic signed [W-1:0] rec_sin, rec_cos;
    logic [W-1:0] rec_ang;

    always @(negedge clk) begin
        if (!rst_n) begin
            cyc = 0; seen = 0; hold_bad = 0;
        end else begin
            cyc++;
            if (valid) begin
                if (!seen) check(cyc == ITER, "R2 first valid cycle", cyc, ITER);
                else       check(cyc - last_cyc == ITER, "R2 valid spacing", cyc - last_cyc, ITER);
                if (seen) check(!hold_bad, "R7 outputs held between pulses", hold_bad, 0);
                seen = 1; last_cyc = cyc; hold_bad = 0;
                if (sb_q.size() == 0) begin
                    check(1'b0, "R3 unexpected sample", 1, 0);
                end else begin
                    exp_t e;
                    real th;
                    int es, ec;
                    e  = sb_q.pop_front();
                    th = 2.0 * PI * real'(e.ang) / 65536.0;
                    es = $rtoi($floor(AMP * $sin(th) + 0.5));
                    ec = $rtoi($floor(AMP * $cos(th) + 0.5));
                    check(ang_v == e.ang, "R3/R5/R6 angle", ang_v, e.ang);
                    check((int'(sin_v) - es <= TOL) && (es - int'(sin_v) <= TOL), "R4 sine", sin_v, es);
                    check((int'(cos_v) - ec <= TOL) && (ec - int'(cos_v) <= TOL), "R4 cosine", cos_v, ec);
                    check(sclk == e.nclk, "R9 synth clock", sclk, e.nclk);
                    check(valid_nc && sin_nc == sin_v && cos_nc == cos_v && ang_nc == ang_v,
                          "R8 tracking equals captured at valid", sin_nc, sin_v);
                end
                rec_sin = sin_v; rec_cos = cos_v; rec_ang = ang_v;
            end else if (seen) begin
                if (sin_v != rec_sin || cos_v != rec_cos || ang_v != rec_ang) hold_bad = 1;
                if (cyc - last_cyc == ITER / 2 && (sin_nc != sin_v || cos_nc != cos_v)) nc_diff++;
            end
        end
    end

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; load = 1'b0; nphase = '0; freq = '0;
        repeat (3) @(negedge clk);
        check(!valid && sin_v == 0 && cos_v == 0 && ang_v == 0 && !sclk, "R1 reset state", sin_v, 0);
        #1 rst_n = 1'b1;
        // static angle
        slot(0, 0, 0, '0);
        slot(0, 0, 0, '0);
        // moderate frequency
        for (int i = 0; i < 6; i++) slot(1000, 0, 0, '0);
        // minimum supported frequency
        for (int i = 0; i < 3; i++) slot(16, 0, 0, '0);
        // load on the boundary edge and mid computation
        slot(1000, 1, 0, 16'h4000);
        slot(1000, 0, 0, '0);
        slot(1000, 1, 5, 16'hC000);
        slot(2000, 1, ITER - 1, 16'h8000);
        slot(2000, 0, 0, '0);
        // quadrant sweep through loads
        for (int i = 0; i < 16; i++) slot(3000, 1, i % ITER, 16'(i * 8191 + 77));
        // fast wrapping frequency
        for (int i = 0; i < 30; i++) slot(300000, 0, 0, '0);
        @(negedge clk);
        check(sb_q.size() == 0, "R3 all samples produced", sb_q.size(), 0);
        check(nc_diff > 0, "R8 tracking outputs move mid computation", nc_diff, 1);
        // asynchronous reset between edges
        #1 rst_n = 1'b0;
        #0.5;
        check(!valid && sin_v == 0 && cos_v == 0 && ang_v == 0 && !sclk && sin_nc == 0,
              "R1 asynchronous reset", sin_v, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule